// File: doc/BRIEF.md
# Two-Wire Serial Byte-Memory Slave

This block is the slave side of a 256-location, byte-wide memory on a two-wire bus whose clock and data lines are open-drain. The system clock samples both bus lines through a short synchronizer. The block finds start and stop conditions in the sampled lines and shifts in the device address, a word address and data bytes. It acknowledges each accepted byte by pulling the data line low for the ninth clock pulse. It serves single-byte writes, random reads and sequential reads from an internal 256x8 array.

A byte write is committed when the stop arrives. An internal write interval then starts, and its length is set by a cycle-count parameter. While it runs, the slave does not answer its own device address, so a master can poll for the end of the write. A standby flag tells whether the slave is idle. The rules that end standby and return to it depend on whether the last operation wrote to the array.

Top module: `e2Slave`

## Requirements
- R1: After reset, `sdaPullLow` is 0 and `standby` is 1, and every array location reads back as 0x00.
- R2: Before the first start condition (SDA falling while SCL is high), clock pulses and data on the bus produce no acknowledge, and `standby` stays 1.
- R3: A device address byte whose upper seven bits, first on the wire, are 1010 followed by the `DEV_SEL` value is acknowledged when the slave is not busy. Bit 0 selects the direction, with 0 for write and 1 for read. The acknowledge holds SDA low through the ninth SCL pulse, and `sdaPullLow` only changes while SCL is low. Any other address byte gets no acknowledge and leaves `standby` unchanged.
- R4: In a write transfer, the slave acknowledges both the word address byte and the data byte. When the stop arrives, the data byte is stored at that word address.
- R5: A random read returns the stored byte. The sequence is a write-direction address, the word address, a repeated start, then a read-direction address. The slave drives the byte most significant bit first and changes SDA only while SCL is low.
- R6: In a sequential read, each byte that the master acknowledges is followed by the byte at the next address, and address 255 is followed by address 0. When the master does not acknowledge, the slave stops driving SDA for the rest of the transfer.
- R7: For `WRITE_CYCLES` clock cycles after a committed write, the slave does not acknowledge its device address. Once that interval has ended, it acknowledges again.
- R8: `standby` goes to 0 when the slave acknowledges its device address. After a stop that ends a transfer with no data byte written, `standby` returns to 1. After a stop that commits a write, `standby` stays 0 until the write interval ends and then goes to 1.
- R9: A start condition in the middle of a byte abandons the transfer in progress. The slave then receives a fresh device address from its first bit, and the abandoned write data is not stored.
- R10: In one write transfer, only the first data byte is accepted. A second data byte gets no acknowledge and is not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Sampled level of the bus clock line |
| sdaIn | input | 1 | Sampled level of the bus data line |
| sdaPullLow | output | 1 | When 1, the data line is pulled low (open-drain enable) |
| standby | output | 1 | 1 while the slave is idle in standby |

## Verification
Some properties are checked on every cycle, in the sampled bus timing:
- the data-line drive never changes while SCL is high;
- a start always resets reception to the first address bit;
- a stop always returns the control to idle;
- the device address is never acknowledged while the write interval is running;
- standby falls only at an address acknowledge, and rises only after a stop or after the write interval ends.

Some behaviour only the bench scenarios can show, because it depends on data carried across whole transfers:
- which byte comes back from which address;
- the wrap from 255 to 0;
- that an abandoned or extra data byte never reaches the array;
- the full length of the busy interval.

// File: rtl/e2SlavePkg.sv
package e2SlavePkg;

  localparam int BYTE_W = 8;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RXDEV,
    ST_ACKDEV,
    ST_RXWORD,
    ST_ACKWORD,
    ST_RXDATA,
    ST_ACKDATA,
    ST_RDATA,
    ST_RACK
  } e2State_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic setAddr;
    logic latchData;
    logic commit;
    logic loadTx;
    logic shiftTx;
    logic ackOn;
    logic txOn;
  } e2Strobe_t;

  // bus events from datapath to control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic start;
    logic stop;
    logic sdaBit;
  } e2BusEv_t;

endpackage

// File: rtl/e2Datapath.sv
module e2Datapath
  import e2SlavePkg::*;
#(
  parameter int MEM_DEPTH    = 256,
  parameter int WRITE_CYCLES = 1000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sclIn,
  input  logic                    sdaIn,
  input  e2Strobe_t               str,
  output e2BusEv_t                ev,
  output logic [BYTE_W-1:0]       rxByte,
  output logic                    busy,
  output logic                    sdaPullLow
);

  localparam int AW  = $clog2(MEM_DEPTH);
  localparam int BCW = $clog2(WRITE_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclP, sdaP;

  // bus line synchronizers, idle level high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclP    <= 1'b1;
      sdaP    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclP    <= sclS;
      sdaP    <= sdaS;
    end
  end

  assign sclS = sclSync[SYNC_STAGES-1];
  assign sdaS = sdaSync[SYNC_STAGES-1];

  always_comb begin
    ev.sclRise = sclS & ~sclP;
    ev.sclFall = ~sclS & sclP;
    ev.start   = sclS & sclP & sdaP & ~sdaS;
    ev.stop    = sclS & sclP & ~sdaP & sdaS;
    ev.sdaBit  = sdaS;
  end

  logic [BYTE_W-1:0] rxShift, txReg, wrData;
  logic [AW-1:0]     addr, wrAddr;
  logic [BYTE_W-1:0] mem [MEM_DEPTH];
  logic [BCW-1:0]    busyCnt;

  assign rxByte = rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
    end else if (str.shiftIn) begin
      rxShift <= {rxShift[BYTE_W-2:0], sdaS};
    end
  end

  // address pointer, transmit register, write holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr   <= '0;
      wrAddr <= '0;
      wrData <= '0;
      txReg  <= '0;
    end else begin
      if (str.setAddr) begin
        addr <= rxShift[AW-1:0];
      end else if (str.latchData) begin
        wrData <= rxShift;
        wrAddr <= addr;
        addr   <= addr + AW'(1);
      end else if (str.loadTx) begin
        txReg <= mem[addr];
        addr  <= addr + AW'(1);
      end else if (str.shiftTx) begin
        txReg <= {txReg[BYTE_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= '0;
    end else if (str.commit) begin
      mem[wrAddr] <= wrData;
    end
  end

  // internal write interval
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt <= '0;
    end else if (str.commit) begin
      busyCnt <= BCW'(WRITE_CYCLES);
    end else if (busyCnt != '0) begin
      busyCnt <= busyCnt - BCW'(1);
    end
  end

  assign busy       = (busyCnt != '0);
  assign sdaPullLow = str.ackOn | (str.txOn & ~txReg[BYTE_W-1]);

  // R3
  pull_stable_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> !sclS);

  // R7
  busy_from_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(str.commit));

endmodule

// File: rtl/e2Ctrl.sv
module e2Ctrl
  import e2SlavePkg::*;
#(
  parameter logic [2:0] DEV_SEL = 3'b000
) (
  input  logic              clk,
  input  logic              rstN,
  input  e2BusEv_t          ev,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              busyIn,
  output e2Strobe_t         str,
  output logic              standby
);

  localparam int CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(BYTE_W);

  e2State_t      state;
  logic [CW-1:0] bitCnt;
  logic          rwBit, pending, masterAck, busyQ;
  logic          devMatch, busyDone, rxState;

  assign devMatch = (rxByte[BYTE_W-1:1] == {DEV_TYPE, DEV_SEL});
  assign busyDone = busyQ & ~busyIn;
  assign rxState  = (state == ST_RXDEV) || (state == ST_RXWORD) || (state == ST_RXDATA);

  always_comb begin
    str = '0;
    str.ackOn = (state == ST_ACKDEV) || (state == ST_ACKWORD) || (state == ST_ACKDATA);
    str.txOn  = (state == ST_RDATA);
    if (!ev.start && !ev.stop) begin
      if (rxState) begin
        if (ev.sclRise && bitCnt < LAST_BIT) str.shiftIn = 1'b1;
        if (ev.sclFall && bitCnt == LAST_BIT) begin
          if (state == ST_RXWORD) str.setAddr = 1'b1;
          if (state == ST_RXDATA) str.latchData = 1'b1;
        end
      end
      case (state)
        ST_ACKDEV: if (ev.sclFall && rwBit) str.loadTx = 1'b1;
        ST_RDATA:  if (ev.sclFall && bitCnt != '0 && bitCnt < LAST_BIT) str.shiftTx = 1'b1;
        ST_RACK:   if (ev.sclFall && masterAck) str.loadTx = 1'b1;
        default: ;
      endcase
    end
    if (ev.stop && pending) str.commit = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      rwBit     <= 1'b0;
      pending   <= 1'b0;
      masterAck <= 1'b0;
      busyQ     <= 1'b0;
      standby   <= 1'b1;
    end else begin
      busyQ <= busyIn;
      if (busyDone) standby <= 1'b1;
      if (ev.start) begin
        state   <= ST_RXDEV;
        bitCnt  <= '0;
        pending <= 1'b0;
      end else if (ev.stop) begin
        state  <= ST_IDLE;
        bitCnt <= '0;
        if (pending) pending <= 1'b0;
        else if (!busyIn) standby <= 1'b1;
      end else begin
        case (state)
          ST_RXDEV, ST_RXWORD, ST_RXDATA: begin
            if (ev.sclRise && bitCnt < LAST_BIT) bitCnt <= bitCnt + CW'(1);
            if (ev.sclFall && bitCnt == LAST_BIT) begin
              bitCnt <= '0;
              if (state == ST_RXDEV) begin
                if (devMatch && !busyIn) begin
                  state   <= ST_ACKDEV;
                  rwBit   <= rxByte[0];
                  standby <= 1'b0;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_RXWORD) begin
                state <= ST_ACKWORD;
              end else begin
                state   <= ST_ACKDATA;
                pending <= 1'b1;
              end
            end
          end
          ST_ACKDEV:  if (ev.sclFall) state <= rwBit ? ST_RDATA : ST_RXWORD;
          ST_ACKWORD: if (ev.sclFall) state <= ST_RXDATA;
          ST_ACKDATA: if (ev.sclFall) state <= ST_IDLE;
          ST_RDATA: begin
            if (ev.sclRise && bitCnt < LAST_BIT) bitCnt <= bitCnt + CW'(1);
            if (ev.sclFall && bitCnt == LAST_BIT) begin
              state  <= ST_RACK;
              bitCnt <= '0;
            end
          end
          ST_RACK: begin
            if (ev.sclRise) masterAck <= ~ev.sdaBit;
            if (ev.sclFall) state <= masterAck ? ST_RDATA : ST_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    ev.start |=> (state == ST_RXDEV && bitCnt == '0));

  // R8
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ev.stop |=> (state == ST_IDLE));

  // R7
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_ACKDEV) |-> !$past(busyIn));

  // R8
  standby_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(standby) |-> (state == ST_ACKDEV));

  // R8
  standby_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(standby) |-> $past(ev.stop || busyDone));

endmodule

// File: rtl/e2Slave.sv
module e2Slave
  import e2SlavePkg::*;
#(
  parameter logic [2:0] DEV_SEL      = 3'b000,
  parameter int         MEM_DEPTH    = 256,
  parameter int         WRITE_CYCLES = 1000,
  parameter int         SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaPullLow,
  output logic standby
);

  e2Strobe_t         str;
  e2BusEv_t          ev;
  logic [BYTE_W-1:0] rxByte;
  logic              busy;

  e2Ctrl #(.DEV_SEL(DEV_SEL)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .ev      (ev),
    .rxByte  (rxByte),
    .busyIn  (busy),
    .str     (str),
    .standby (standby)
  );

  e2Datapath #(
    .MEM_DEPTH    (MEM_DEPTH),
    .WRITE_CYCLES (WRITE_CYCLES),
    .SYNC_STAGES  (SYNC_STAGES)
  ) i_data (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .str        (str),
    .ev         (ev),
    .rxByte     (rxByte),
    .busy       (busy),
    .sdaPullLow (sdaPullLow)
  );

endmodule

// File: tb/test_e2Slave.sv
`timescale 1ns/1ps
module test_e2Slave;

  localparam int H      = 20;
  localparam int WR_CYC = 1000;
  localparam logic [7:0] DEV_W = 8'hA4;
  localparam logic [7:0] DEV_R = 8'hA5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic sdaPullLow, standby;
  logic sdaLine;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model of the array contents
  int refMem [256];

  always #5 clk = ~clk;

  assign sdaLine = mSda & ~sdaPullLow;

  e2Slave #(.DEV_SEL(3'b010), .WRITE_CYCLES(WR_CYC)) i_e2Slave (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (mScl),
    .sdaIn      (sdaLine),
    .sdaPullLow (sdaPullLow),
    .standby    (standby)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // every clock: the slave's drive must not change while SCL is high (R3)
  logic pullPrev = 1'b0;
  int monFails = 0;
  always @(negedge clk) begin
    if (rstN && (sdaPullLow != pullPrev) && mScl) monFails++;
    pullPrev <= sdaPullLow;
  end

  task automatic startC();
    mSda = 1'b1; waitClk(H);
    mScl = 1'b1; waitClk(H);
    mSda = 1'b0; waitClk(H);
    mScl = 1'b0; waitClk(H);
  endtask

  task automatic stopC();
    waitClk(2);
    mSda = 1'b0; waitClk(H);
    mScl = 1'b1; waitClk(H);
    mSda = 1'b1; waitClk(H);
  endtask

  task automatic clockBit(input logic b, output logic s);
    waitClk(2);
    mSda = b; waitClk(H);
    mScl = 1'b1; waitClk(H/2);
    s = sdaLine; waitClk(H/2);
    mScl = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(b[i], s);
    clockBit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recvByte(output logic [7:0] d, input logic giveAck);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, s);
      d[i] = s;
    end
    clockBit(~giveAck, s);
  endtask

  task automatic writeTxn(input logic [7:0] a, input logic [7:0] d);
    logic ack;
    startC();
    sendByte(DEV_W, ack); check("R4 dev ack", int'(ack), 1);
    sendByte(a, ack);     check("R4 word ack", int'(ack), 1);
    sendByte(d, ack);     check("R4 data ack", int'(ack), 1);
    stopC();
    refMem[a] = int'(d);
    waitClk(WR_CYC + 40);
  endtask

  task automatic setReadAddr(input logic [7:0] a);
    logic ack;
    startC();
    sendByte(DEV_W, ack); check("R5 dev ack", int'(ack), 1);
    sendByte(a, ack);     check("R5 word ack", int'(ack), 1);
    startC();
    sendByte(DEV_R, ack); check("R5 read dev ack", int'(ack), 1);
  endtask

  initial begin
    logic ack, s;
    logic [7:0] d;
    for (int i = 0; i < 256; i++) refMem[i] = 0;

    waitClk(5);
    rstN = 1'b1;
    waitClk(3);
    // R1 reset state
    check("R1 pull after reset", int'(sdaPullLow), 0);
    check("R1 standby after reset", int'(standby), 1);

    // R2 traffic without a start
    mScl = 1'b0; waitClk(H);
    sendByte(DEV_W, ack);
    check("R2 no ack before start", int'(ack), 0);
    waitClk(2); mSda = 1'b1; waitClk(H); mScl = 1'b1; waitClk(H);
    check("R2 standby kept", int'(standby), 1);

    // R3 address mismatch
    startC();
    sendByte(8'hA0, ack);
    check("R3 mismatch nack", int'(ack), 0);
    stopC(); waitClk(8);
    check("R3 mismatch standby", int'(standby), 1);

    // R4 byte write, R8 standby held during write interval
    startC();
    sendByte(DEV_W, ack); check("R3 dev ack", int'(ack), 1);
    sendByte(8'h10, ack); check("R4 word ack", int'(ack), 1);
    sendByte(8'h5A, ack); check("R4 data ack", int'(ack), 1);
    stopC(); refMem[8'h10] = 'h5A;
    waitClk(8);
    check("R8 standby after write stop", int'(standby), 0);

    // R7 polling while busy
    startC();
    sendByte(DEV_W, ack); check("R7 nack while busy", int'(ack), 0);
    stopC(); waitClk(8);
    check("R8 standby while busy", int'(standby), 0);
    waitClk(WR_CYC + 40);
    check("R8 standby after write interval", int'(standby), 1);
    startC();
    sendByte(DEV_W, ack); check("R7 ack after interval", int'(ack), 1);
    waitClk(4);
    check("R8 standby cleared by ack", int'(standby), 0);
    stopC(); waitClk(8);
    check("R8 standby after non-write stop", int'(standby), 1);

    // R5 random read
    setReadAddr(8'h10);
    recvByte(d, 1'b0);
    check("R5 read data", int'(d), refMem[8'h10]);
    clockBit(1'b1, s);
    check("R6 released after nack", int'(s), 1);
    stopC(); waitClk(8);
    check("R8 standby after read", int'(standby), 1);

    // R10 second data byte refused
    startC();
    sendByte(DEV_W, ack); check("R10 dev ack", int'(ack), 1);
    sendByte(8'h20, ack); check("R10 word ack", int'(ack), 1);
    sendByte(8'h11, ack); check("R10 first data ack", int'(ack), 1);
    sendByte(8'h22, ack); check("R10 second data nack", int'(ack), 0);
    stopC(); refMem[8'h20] = 'h11;
    waitClk(WR_CYC + 40);

    // R6 sequential read with wrap
    writeTxn(8'hFF, 8'hA5);
    writeTxn(8'h00, 8'h3C);
    setReadAddr(8'hFF);
    recvByte(d, 1'b1); check("R6 byte at 255", int'(d), refMem[255]);
    recvByte(d, 1'b1); check("R6 wrap to 0", int'(d), refMem[0]);
    recvByte(d, 1'b0); check("R6 byte at 1", int'(d), refMem[1]);
    clockBit(1'b1, s);
    check("R6 released after nack", int'(s), 1);
    stopC(); waitClk(8);

    // R9 start in the middle of a data byte
    startC();
    sendByte(DEV_W, ack); check("R9 dev ack", int'(ack), 1);
    sendByte(8'h30, ack); check("R9 word ack", int'(ack), 1);
    clockBit(1'b0, s); clockBit(1'b1, s); clockBit(1'b1, s); clockBit(1'b1, s);
    startC();
    sendByte(DEV_W, ack); check("R9 address after restart", int'(ack), 1);
    sendByte(8'h30, ack); check("R9 word after restart", int'(ack), 1);
    startC();
    sendByte(DEV_R, ack); check("R9 read dev ack", int'(ack), 1);
    recvByte(d, 1'b0);
    check("R9 aborted data not stored", int'(d), refMem[8'h30]);
    stopC(); waitClk(8);
    check("R9 standby, nothing written", int'(standby), 1);

    // R10 only first byte stored
    setReadAddr(8'h20);
    recvByte(d, 1'b1); check("R10 first byte stored", int'(d), refMem[8'h20]);
    recvByte(d, 1'b0); check("R10 second byte not stored", int'(d), refMem[8'h21]);
    stopC(); waitClk(8);

    check("R3 drive stable while SCL high", monFails, 0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule